// File: doc/BRIEF.md
# SD Host Single-Operation DMA Boundary Engine

This block is the single-operation DMA part of an SD/MMC host controller. Software programs a system memory address, a block length, a buffer boundary code, a block count and a transfer mode through a small register bus. It then writes a command word with its data-present flag set. The engine moves 32-bit words between the card data FIFO and a simple memory port. Each word goes to the next word address.

The engine stops whenever the next address reaches a multiple of the programmed buffer boundary. At that point it raises a DMA status bit and issues no memory requests until software rewrites the system address register. Software normally reads the address back and writes it again unchanged, or writes a new buffer address. The block count drops by one after each finished block. When the last counted block is done, the engine goes idle and sets transfer complete. Status bits are cleared by writing 1 to them. Each bit is seen only through a status-enable mask, and a signal-enable mask selects which bits drive the interrupt output.

Register words, selected by `reg_addr_i`:
- 0: system address, live
- 1: block. [11:0] is the length in bytes, [14:12] the boundary code, [31:16] the block count (live)
- 2: transfer mode
- 3: host control
- 4: command
- 5: status
- 6: status enable
- 7: signal enable

Top module: `sdma_engine`

## Requirements
- R1: After reset, the address reads 0, the visible status reads 0, `irq_o` is 0 and `mem_valid_o` is 0.
- R2: Transfer mode fields are bit 0 DMA enable, bit 1 block count enable, bit 4 direction (1 = card to memory) and bit 5 multi-block. A transfer starts when the command word (register 4) is written with bit 5 set, while mode bit 0 is set.
- R3: With direction 1, card FIFO words are written to memory. With direction 0, memory words are read and passed to the card FIFO. In both cases the address rises by 4 per word, starting at the system address.
- R4: The boundary is 4096 << code bytes. When the address after a word is a multiple of the boundary and the transfer is not ending, the engine pauses. It then sets status bit 3 and requests nothing from memory.
- R5: Writing register 0 while paused resumes the transfer at the written address.
- R6: Writing register 0 while idle only loads the address. No transfer starts.
- R7: With count enable set, the block count decrements after each finished block, and the transfer completes after the block that leaves it at 0. With multi-block clear, the transfer completes after one block. Completion sets status bit 1 and returns the engine to idle.
- R8: When the final word of a transfer lands exactly on a boundary, status bit 1 is set and status bit 3 stays clear.
- R9: Any command write sets status bit 0. Writing 1 to a status bit in register 5 clears it.
- R10: Register 5 reads status ANDed with the status enable (register 6). `irq_o` is the OR of status ANDed with both enables (registers 6 and 7).
- R11: With host control bits [4:3] other than 00, a data command moves no data. Only status bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request |
| cf_rd_valid_i | input | 1 | Card FIFO has a word for memory |
| cf_rd_data_i | input | 32 | Card FIFO word toward memory |
| cf_rd_ready_o | output | 1 | Engine takes the card FIFO word |
| cf_wr_valid_o | output | 1 | Word toward card FIFO is valid |
| cf_wr_data_o | output | 32 | Word toward card FIFO |
| cf_wr_ready_i | input | 1 | Card FIFO can take a word |
| mem_valid_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, same cycle |
| mem_ready_i | input | 1 | Memory accepts the request |

## Verification
The last word of a block can also be the word that reaches a buffer boundary. The engine must then decide between pausing and finishing in the same cycle.

Three cases provoke this:
- A one-block transfer that ends exactly on a 4 KiB line. It must set transfer complete only, with the DMA bit clear (R8).
- A three-block transfer whose first block ends on a boundary. It must pause with the count already at 2.
- A transfer that crosses a 4 KiB line under boundary code 1. It must not pause.

In every case, each memory beat is compared against a queue of expected address and data pairs built from the programmed values.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_ADDR   = 3'd0;
  localparam logic [REG_AW-1:0] RA_BLK    = 3'd1;
  localparam logic [REG_AW-1:0] RA_MODE   = 3'd2;
  localparam logic [REG_AW-1:0] RA_HCTL   = 3'd3;
  localparam logic [REG_AW-1:0] RA_CMD    = 3'd4;
  localparam logic [REG_AW-1:0] RA_STS    = 3'd5;
  localparam logic [REG_AW-1:0] RA_STS_EN = 3'd6;
  localparam logic [REG_AW-1:0] RA_SIG_EN = 3'd7;

  // mode bit positions
  localparam int unsigned MB_DMA   = 0;
  localparam int unsigned MB_CNT   = 1;
  localparam int unsigned MB_DIR   = 4;
  localparam int unsigned MB_MULTI = 5;
  // command data-present flag, host control select field
  localparam int unsigned CB_DATA  = 5;
  localparam int unsigned DSEL_LSB = 3;
  // status bit positions
  localparam int unsigned SB_CMD  = 0;
  localparam int unsigned SB_XFER = 1;
  localparam int unsigned SB_DMA  = 3;
  localparam logic [7:0]  STS_IMPL = 8'h0B;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MOVE  = 2'd1,
    ST_PAUSE = 2'd2
  } sdma_state_e;

  typedef struct packed {
    logic multi;
    logic to_mem;
    logic cnt_en;
    logic dma_en;
  } xfer_cfg_t;
endpackage

// File: rtl/sdma_bound.sv
module sdma_bound #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BOUND_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] mask;

  // low bits that must be zero for a boundary of 2^(BOUND_LOG2+code)
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign mask[i] = (32'(i) < (32'(BOUND_LOG2) + 32'(code_i)));
  end

  assign hit_o = ~|(addr_i & mask);
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned CODE_W = 3,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [CNT_W-1:0]  cnt_q_i,
  input  logic              done_i,
  input  logic              pause_i,
  output xfer_cfg_t         cfg_o,
  output logic [LEN_W-1:0]  blk_len_o,
  output logic [CODE_W-1:0] code_o,
  output logic              start_o,
  output logic              addr_wr_o,
  output logic              cnt_wr_o,
  output logic              irq_o
);
  localparam int unsigned NREG    = 1 << REG_AW;
  localparam int unsigned CNT_LSB = 32 - CNT_W;

  logic [LEN_W-1:0]  blk_len_q;
  logic [CODE_W-1:0] code_q;
  logic [5:0]        mode_q;
  logic [7:0]        hctl_q;
  logic [15:0]       cmd_q;
  logic [7:0]        sts_q, sts_en_q, sig_en_q;
  logic [NREG-1:0]   wsel;
  logic [7:0]        sts_set, sts_clr;

  assign wsel = reg_we_i ? (NREG'(1) << reg_addr_i) : '0;

  assign start_o   = wsel[RA_CMD] && reg_wdata_i[CB_DATA] &&
                     (hctl_q[DSEL_LSB +: 2] == 2'b00);
  assign addr_wr_o = wsel[RA_ADDR];
  assign cnt_wr_o  = wsel[RA_BLK];

  always_comb begin
    sts_set          = '0;
    sts_set[SB_CMD]  = wsel[RA_CMD];
    sts_set[SB_XFER] = done_i;
    sts_set[SB_DMA]  = pause_i;
    sts_clr          = wsel[RA_STS] ? reg_wdata_i[7:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_len_q <= '0;
      code_q    <= '0;
      mode_q    <= '0;
      hctl_q    <= '0;
      cmd_q     <= '0;
      sts_q     <= '0;
      sts_en_q  <= '0;
      sig_en_q  <= '0;
    end else begin
      if (wsel[RA_BLK]) begin
        blk_len_q <= reg_wdata_i[LEN_W-1:0];
        code_q    <= reg_wdata_i[LEN_W +: CODE_W];
      end
      if (wsel[RA_MODE])   mode_q   <= reg_wdata_i[5:0];
      if (wsel[RA_HCTL])   hctl_q   <= reg_wdata_i[7:0];
      if (wsel[RA_CMD])    cmd_q    <= reg_wdata_i[15:0];
      if (wsel[RA_STS_EN]) sts_en_q <= reg_wdata_i[7:0];
      if (wsel[RA_SIG_EN]) sig_en_q <= reg_wdata_i[7:0];
      // set wins over a same-cycle clear
      sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_IMPL;
    end
  end

  assign cfg_o.dma_en = mode_q[MB_DMA];
  assign cfg_o.cnt_en = mode_q[MB_CNT];
  assign cfg_o.to_mem = mode_q[MB_DIR];
  assign cfg_o.multi  = mode_q[MB_MULTI];
  assign blk_len_o    = blk_len_q;
  assign code_o       = code_q;

  assign irq_o = |(sts_q & sts_en_q & sig_en_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_ADDR:   reg_rdata_o = 32'(addr_q_i);
      RA_BLK: begin
        reg_rdata_o[LEN_W-1:0]         = blk_len_q;
        reg_rdata_o[LEN_W +: CODE_W]   = code_q;
        reg_rdata_o[CNT_LSB +: CNT_W]  = cnt_q_i;
      end
      RA_MODE:   reg_rdata_o = {26'd0, mode_q};
      RA_HCTL:   reg_rdata_o = {24'd0, hctl_q};
      RA_CMD:    reg_rdata_o = {16'd0, cmd_q};
      RA_STS:    reg_rdata_o = {24'd0, sts_q & sts_en_q};
      RA_STS_EN: reg_rdata_o = {24'd0, sts_en_q};
      RA_SIG_EN: reg_rdata_o = {24'd0, sig_en_q};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BOUND_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_cfg_t         cfg_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              start_i,
  input  logic              addr_wr_i,
  input  logic              cnt_wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              cf_rd_valid_i,
  input  logic [DATA_W-1:0] cf_rd_data_i,
  output logic              cf_rd_ready_o,
  output logic              cf_wr_valid_o,
  output logic [DATA_W-1:0] cf_wr_data_o,
  input  logic              cf_wr_ready_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output sdma_state_e       state_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [CNT_W-1:0]  cnt_q_o,
  output logic              fire_o,
  output logic              done_o,
  output logic              pause_o
);
  localparam int unsigned BYTES   = DATA_W / 8;
  localparam int unsigned BEAT_SH = $clog2(BYTES);
  localparam int unsigned CNT_LSB = 32 - CNT_W;

  sdma_state_e      state_q;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  beat_q, beats;
  logic              moving, fire, blk_last, xfer_end, bnd_hit, go;

  assign moving   = (state_q == ST_MOVE);
  assign fire     = moving && mem_ready_i &&
                    (cfg_i.to_mem ? cf_rd_valid_i : cf_wr_ready_i);
  assign addr_nx  = addr_q + ADDR_W'(BYTES);
  assign beats    = blk_len_i >> BEAT_SH;
  assign blk_last = (beats == '0) || (beat_q == beats - LEN_W'(1));
  assign xfer_end = !cfg_i.multi || (cfg_i.cnt_en && cnt_q == CNT_W'(1));
  assign go       = start_i && cfg_i.dma_en && !(cfg_i.cnt_en && cnt_q == '0);

  sdma_bound #(
    .ADDR_W    (ADDR_W),
    .CODE_W    (CODE_W),
    .BOUND_LOG2(BOUND_LOG2)
  ) u_bound (
    .addr_i(addr_nx),
    .code_i(code_i),
    .hit_o (bnd_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (addr_wr_i) addr_q <= wdata_i[ADDR_W-1:0];
          if (cnt_wr_i)  cnt_q  <= wdata_i[CNT_LSB +: CNT_W];
          if (go) begin
            state_q <= ST_MOVE;
            beat_q  <= '0;
          end
        end
        ST_MOVE: begin
          if (fire) begin
            addr_q <= addr_nx;
            if (blk_last) begin
              beat_q <= '0;
              if (cfg_i.cnt_en) cnt_q <= cnt_q - CNT_W'(1);
              // completion outranks a boundary on the same word
              if (xfer_end)     state_q <= ST_IDLE;
              else if (bnd_hit) state_q <= ST_PAUSE;
            end else begin
              beat_q <= beat_q + LEN_W'(1);
              if (bnd_hit) state_q <= ST_PAUSE;
            end
          end
        end
        ST_PAUSE: begin
          if (addr_wr_i) begin
            addr_q  <= wdata_i[ADDR_W-1:0];
            state_q <= ST_MOVE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid_o   = moving && (cfg_i.to_mem ? cf_rd_valid_i : cf_wr_ready_i);
  assign mem_we_o      = cfg_i.to_mem;
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = cf_rd_data_i;
  assign cf_rd_ready_o = moving && cfg_i.to_mem && mem_ready_i;
  assign cf_wr_valid_o = moving && !cfg_i.to_mem && mem_ready_i;
  assign cf_wr_data_o  = mem_rdata_i;

  assign done_o   = fire && blk_last && xfer_end;
  assign pause_o  = fire && bnd_hit && !(blk_last && xfer_end);
  assign fire_o   = fire;
  assign state_o  = state_q;
  assign addr_q_o = addr_q;
  assign cnt_q_o  = cnt_q;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BOUND_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  input  logic              cf_rd_valid_i,
  input  logic [DATA_W-1:0] cf_rd_data_i,
  output logic              cf_rd_ready_o,
  output logic              cf_wr_valid_o,
  output logic [DATA_W-1:0] cf_wr_data_o,
  input  logic              cf_wr_ready_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  xfer_cfg_t         cfg;
  logic [LEN_W-1:0]  blk_len;
  logic [CODE_W-1:0] code;
  logic              start, addr_wr, cnt_wr;
  sdma_state_e       mv_state;
  logic [ADDR_W-1:0] mv_addr;
  logic [CNT_W-1:0]  mv_cnt;
  logic              beat_fire, xfer_done, dma_pause;

  sdma_regs #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .addr_q_i   (mv_addr),
    .cnt_q_i    (mv_cnt),
    .done_i     (xfer_done),
    .pause_i    (dma_pause),
    .cfg_o      (cfg),
    .blk_len_o  (blk_len),
    .code_o     (code),
    .start_o    (start),
    .addr_wr_o  (addr_wr),
    .cnt_wr_o   (cnt_wr),
    .irq_o      (irq_o)
  );

  sdma_mover #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .BOUND_LOG2(BOUND_LOG2)
  ) u_mover (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .blk_len_i    (blk_len),
    .code_i       (code),
    .start_i      (start),
    .addr_wr_i    (addr_wr),
    .cnt_wr_i     (cnt_wr),
    .wdata_i      (reg_wdata_i),
    .cf_rd_valid_i(cf_rd_valid_i),
    .cf_rd_data_i (cf_rd_data_i),
    .cf_rd_ready_o(cf_rd_ready_o),
    .cf_wr_valid_o(cf_wr_valid_o),
    .cf_wr_data_o (cf_wr_data_o),
    .cf_wr_ready_i(cf_wr_ready_i),
    .mem_valid_o  (mem_valid_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_ready_i  (mem_ready_i),
    .state_o      (mv_state),
    .addr_q_o     (mv_addr),
    .cnt_q_o      (mv_cnt),
    .fire_o       (beat_fire),
    .done_o       (xfer_done),
    .pause_o      (dma_pause)
  );
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input sdma_state_e       state_i,
  input logic              mem_valid_i,
  input logic              addr_wr_i,
  input logic [31:0]       wdata_i,
  input logic [ADDR_W-1:0] addr_q_i,
  input logic [CNT_W-1:0]  cnt_q_i,
  input logic              fire_i,
  input logic              done_i,
  input logic              pause_i,
  input logic              cnt_en_i,
  input logic              multi_i
);
  localparam int unsigned BYTES = DATA_W / 8;

  // R4
  pause_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_PAUSE |-> !mem_valid_i);

  // R5
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PAUSE && addr_wr_i) |=>
      (state_i == ST_MOVE && addr_q_i == $past(wdata_i[ADDR_W-1:0])));

  // R6
  idle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && addr_wr_i) |=>
      (state_i == ST_IDLE && addr_q_i == $past(wdata_i[ADDR_W-1:0])));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> addr_q_i == $past(addr_q_i) + ADDR_W'(BYTES));

  // R8
  end_vs_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && pause_i));

  // R7
  count_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cnt_en_i && multi_i) |=> cnt_q_i == '0);
endmodule

bind sdma_engine sdma_engine_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (mv_state),
  .mem_valid_i(mem_valid_o),
  .addr_wr_i  (addr_wr),
  .wdata_i    (reg_wdata_i),
  .addr_q_i   (mv_addr),
  .cnt_q_i    (mv_cnt),
  .fire_i     (beat_fire),
  .done_i     (xfer_done),
  .pause_i    (dma_pause),
  .cnt_en_i   (cfg.cnt_en),
  .multi_i    (cfg.multi)
);

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        cf_rd_valid_i = 1'b0;
  logic [31:0] src_word = 32'h1000_0000;
  logic        cf_rd_ready;
  logic        cf_wr_valid;
  logic [31:0] cf_wr_data;
  logic        cf_wr_ready_i = 1'b0;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready_i = 1'b0;
  logic [7:0]  tick = '0;

  int n_chk = 0;
  int n_err = 0;
  int n_pop = 0;
  bit done_flag = 0;
  logic [64:0] exp_q[$];

  always #10 clk = ~clk;

  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;

  sdma_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq),
    .cf_rd_valid_i(cf_rd_valid_i), .cf_rd_data_i(src_word), .cf_rd_ready_o(cf_rd_ready),
    .cf_wr_valid_o(cf_wr_valid), .cf_wr_data_o(cf_wr_data), .cf_wr_ready_i(cf_wr_ready_i),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready_i)
  );

  // handshake stalls and card source
  always @(posedge clk) begin
    tick          <= tick + 8'd1;
    mem_ready_i   <= (tick % 3) != 2;
    cf_wr_ready_i <= tick[2:0] != 3'd5;
    cf_rd_valid_i <= tick[1:0] != 2'd0;
    if (cf_rd_valid_i && cf_rd_ready) src_word <= src_word + 32'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every accepted memory beat against the expected queue
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready_i) begin
      logic [64:0] e;
      logic [31:0] d;
      d = mem_we ? mem_wdata : cf_wr_data;
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R6/R11 unexpected beat: actual=%h expected=none", mem_addr);
      end else begin
        e = exp_q.pop_front();
        n_pop++;
        chk("R3 dir", {31'd0, mem_we}, {31'd0, e[64]});
        chk("R3 addr", mem_addr, e[63:32]);
        chk("R3 data", d, e[31:0]);
        if (!mem_we) chk("R3 card valid", {31'd0, cf_wr_valid}, 32'd1);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_sts(input logic [31:0] m, input string req);
    logic [31:0] v = '0;
    int k = 0;
    while (((v & m) == 0) && k < 4000) begin
      rd(3'd5, v);
      k++;
    end
    if (k >= 4000) begin
      n_chk++; n_err++;
      $display("FAIL %s status wait: actual=%h expected=%h", req, v, m);
    end
  endtask

  // driver: expected beats for one contiguous segment
  task automatic push_seg(input logic wr_dir, input logic [31:0] a0, input int n, input logic [31:0] d0);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = a0 + 32'(4 * i);
      exp_q.push_back({wr_dir, a, wr_dir ? d0 + 32'(i) : (a ^ 32'h5A5A_0000)});
    end
  endtask

  function automatic logic [31:0] blk(input int cnt, input int code, input int len);
    return {16'(cnt), 1'b0, 3'(code), 12'(len)};
  endfunction

  initial begin
    int p;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    rd_chk("R1 addr", 3'd0, 32'd0);
    wr(3'd6, 32'h3B);
    rd_chk("R1 status", 3'd5, 32'd0);
    wr(3'd7, 32'h02);

    // A: card to memory, pause at 0x1000, resume same address, 4 blocks of 256 B
    wr(3'd0, 32'h0000_0F80);
    wr(3'd1, blk(4, 0, 256));
    wr(3'd2, 32'h33);
    push_seg(1'b1, 32'h0F80, 32, src_word);
    push_seg(1'b1, 32'h1000, 224, src_word + 32);
    wr(3'd4, 32'h0000_1120);
    wait_sts(32'h08, "R4");
    p = n_pop;
    repeat (20) @(posedge clk);
    chk("R4 no beats while paused", 32'(n_pop), 32'(p));
    chk("R4 beats before boundary", 32'(n_pop), 32'd32);
    rd_chk("R4 paused address", 3'd0, 32'h1000);
    rd_chk("R7 count before first block end", 3'd1, blk(4, 0, 256));
    wr(3'd5, 32'h08);
    rd_chk("R9 dma bit cleared", 3'd5, 32'h01);
    wr(3'd0, 32'h1000);
    begin
      int k = 0;
      while (!irq && k < 4000) begin @(negedge clk); k++; end
    end
    chk("R10 irq on complete", {31'd0, irq}, 32'd1);
    chk("R7 all beats done", 32'(exp_q.size()), 32'd0);
    rd_chk("R7 count zero", 3'd1, blk(0, 0, 256));
    rd_chk("R3 end address", 3'd0, 32'h1380);
    rd_chk("R7 complete status", 3'd5, 32'h03);
    wr(3'd5, 32'hFF);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    // B: idle load, then memory to card with block end on boundary, resume elsewhere
    p = n_pop;
    wr(3'd0, 32'h3000);
    repeat (10) @(posedge clk);
    chk("R6 idle write no beats", 32'(n_pop), 32'(p));
    rd_chk("R6 idle address loaded", 3'd0, 32'h3000);
    rd_chk("R6 no status", 3'd5, 32'h0);
    wr(3'd0, 32'h3FF0);
    wr(3'd1, blk(3, 0, 16));
    wr(3'd2, 32'h23);
    push_seg(1'b0, 32'h3FF0, 4, 32'h0);
    push_seg(1'b0, 32'h8000, 8, 32'h0);
    wr(3'd4, 32'h0000_1220);
    wait_sts(32'h08, "R4");
    rd_chk("R7 count after block on boundary", 3'd1, blk(2, 0, 16));
    rd_chk("R4 paused at boundary", 3'd0, 32'h4000);
    wr(3'd5, 32'h08);
    wr(3'd0, 32'h8000);
    wait_sts(32'h02, "R5");
    chk("R5 resumed beats done", 32'(exp_q.size()), 32'd0);
    rd_chk("R5 end address", 3'd0, 32'h8020);
    rd_chk("R7 count zero", 3'd1, blk(0, 0, 16));
    rd_chk("R7 status", 3'd5, 32'h03);
    wr(3'd5, 32'hFF);

    // C: final word lands on boundary
    wr(3'd0, 32'h4F00);
    wr(3'd1, blk(1, 0, 256));
    wr(3'd2, 32'h13);
    push_seg(1'b1, 32'h4F00, 64, src_word);
    wr(3'd4, 32'h0000_1120);
    wait_sts(32'h0A, "R8");
    repeat (3) @(posedge clk);
    rd_chk("R8 complete not dma", 3'd5, 32'h03);
    rd_chk("R8 address at boundary", 3'd0, 32'h5000);
    chk("R8 beats", 32'(exp_q.size()), 32'd0);
    wr(3'd5, 32'hFF);

    // D: code 1 gives 8 KiB, 0x5000 is no stop
    wr(3'd0, 32'h4F80);
    wr(3'd1, blk(2, 1, 128));
    wr(3'd2, 32'h33);
    push_seg(1'b1, 32'h4F80, 64, src_word);
    wr(3'd4, 32'h0000_1120);
    wait_sts(32'h0A, "R4");
    repeat (3) @(posedge clk);
    rd_chk("R4 code 1 no pause", 3'd5, 32'h03);
    rd_chk("R4 code 1 end address", 3'd0, 32'h5080);
    wr(3'd5, 32'hFF);

    // E: non-zero select moves nothing
    wr(3'd3, 32'h10);
    wr(3'd0, 32'h9000);
    wr(3'd1, blk(1, 0, 16));
    wr(3'd2, 32'h13);
    p = n_pop;
    wr(3'd4, 32'h0000_1120);
    repeat (20) @(posedge clk);
    chk("R11 no beats", 32'(n_pop), 32'(p));
    rd_chk("R11 only command bit", 3'd5, 32'h01);
    rd_chk("R11 count kept", 3'd1, blk(1, 0, 16));
    wr(3'd3, 32'h00);
    wr(3'd5, 32'hFF);

    // F: enables
    wr(3'd6, 32'h00);
    wr(3'd4, 32'h0000_0100);
    rd_chk("R10 masked status", 3'd5, 32'h0);
    chk("R10 masked irq", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h01);
    rd_chk("R9 command bit set", 3'd5, 32'h01);
    chk("R10 signal enable off", {31'd0, irq}, 32'd0);
    wr(3'd7, 32'h01);
    @(negedge clk);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'h01);
    @(negedge clk);
    chk("R9 w1c clears irq", {31'd0, irq}, 32'd0);

    // G: single-block mode with count 3
    wr(3'd6, 32'h3B);
    wr(3'd1, blk(3, 0, 16));
    wr(3'd2, 32'h13);
    push_seg(1'b1, 32'h9000, 4, src_word);
    wr(3'd4, 32'h0000_1120);
    wait_sts(32'h02, "R7");
    repeat (3) @(posedge clk);
    rd_chk("R7 single block count", 3'd1, blk(2, 0, 16));
    chk("R2 start and one block", 32'(exp_q.size()), 32'd0);

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule